// File: doc/BRIEF.md
# Per-Model Queue Scheduler with Reload Insertion

This block decides which of several request queues feeds one downstream processing pipeline. Every queue holds requests for a single scoring model. A downstream stage must load a model's tables before it can score requests for that model, and that load costs far more than scoring one request. The scheduler therefore stays on one queue as long as it can. It sends that queue's requests one at a time. It leaves the queue only when the queue runs dry or a programmable dwell window expires.

When a queue is selected, the scheduler compares the queue's model with the model that downstream stages last loaded. If the two differ, the scheduler first emits a reload command tagged with the new model identifier. Requests from the new queue follow only after that command. A new queue is found by a round-robin scan that starts at the queue after the current one and skips empty queues. When every queue is empty, the scheduler waits and keeps its record of the loaded model.

Top module: `model_queue_sched`

## Requirements
- R1: After reset, `outValid` and every `reqReady` bit are 0, and no model counts as loaded. The first queue selected after reset therefore always gets a reload command.
- R2: Each request transfer drives `outIsReload`=0, `outData` equal to the selected queue's `reqData` slice, and `outModel` equal to that queue's model. In that cycle exactly one `reqReady` bit is 1: the bit of the selected queue, and only while `outReady` is 1.
- R3: Requests from a selected queue leave in arrival order. No request from any other queue comes between them until the scheduler switches.
- R4: When the selected queue has no valid request, the scheduler switches. The next queue is the first one with a valid request in the scan order current+1, current+2, … with wraparound. The current queue itself comes last in that scan.
- R5: On a switch to a queue whose model differs from the loaded one, one reload command is emitted before any of that queue's requests. The command has `outValid`=1, `outIsReload`=1, `outModel`=the new model and `outData`=0. The model counts as loaded once the command is accepted.
- R6: On a switch to a queue whose model equals the loaded one, no reload command is emitted and requests start at once.
- R7: While a reload command is not accepted (`outReady`=0), it stays on the output with the same model, and no `reqReady` bit is raised.
- R8: For a nonzero `timeoutCfg` of T, a dwell counter starts at 0 in the first cycle after selection and increments every cycle, reload cycles included. No request is issued in a cycle where the counter is at least T, and the scheduler switches in that cycle. If a reload comes first and the output is never stalled, at most T-1 requests are issued per visit; without a reload, at most T. A `timeoutCfg` of 0 disables the limit.
- R9: When the dwell window expires and the current queue is the only non-empty one, that same queue is selected again with no reload command.
- R10: With every queue empty, `outValid` and `reqReady` stay 0. The loaded model is kept, so a later queue that uses it needs no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_Q | Per-queue request present |
| reqReady | output | NUM_Q | Per-queue request taken this cycle |
| reqData | input | NUM_Q*DATA_W | Per-queue request payload, queue q at bits [q*DATA_W +: DATA_W] |
| queueModel | input | NUM_Q*MODEL_W | Model identifier of each queue, queue q at bits [q*MODEL_W +: MODEL_W] |
| timeoutCfg | input | TMR_W | Dwell limit in cycles, 0 = no limit |
| outValid | output | 1 | Output item present |
| outReady | input | 1 | Downstream accepts output item |
| outIsReload | output | 1 | 1 = reload command, 0 = request |
| outModel | output | MODEL_W | Model of the request or of the reload |
| outData | output | DATA_W | Request payload, 0 on reload commands |

## Verification
The main sweep loads every combination of 0 to 2 pending requests per queue. This is done under three model assignments: all models distinct, models shared in pairs, and all queues on one model. These three separate the reload decision from queue rotation, because reloads should appear on every switch, on some switches, or only once. Each combination runs with no dwell limit, which isolates drain-until-empty ordering. It also runs with two short limits, which force partial visits and self-reselection. A further pass repeats the sweep with periodic output stalls, so that reloads held under backpressure are seen against the same transfer order that an unstalled run gives.

// File: rtl/qs_pkg.sv
package qs_pkg;

  typedef enum logic [1:0] {
    SCH_IDLE   = 2'd0,
    SCH_RELOAD = 2'd1,
    SCH_DRAIN  = 2'd2
  } schedState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic showReload;   // present reload command on output
    logic showReq;      // present request of the selected queue
    logic commitModel;  // reload accepted, record the model as loaded
  } schedStrobe_t;

endpackage

// File: rtl/qs_ctrl.sv
module qs_ctrl
  import qs_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int TMR_W = 8,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_Q-1:0]   reqValid,
  input  logic [TMR_W-1:0]   timeoutCfg,
  input  logic               outReady,
  input  logic               candMatch,
  output logic [QW-1:0]      curQ,
  output logic [QW-1:0]      candQ,
  output schedStrobe_t       strobe
);

  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  schedState_e      state;
  logic [TMR_W-1:0] dwellCnt;
  logic [TMR_W-1:0] dwellNext;
  logic             anyValid;
  logic             expired;
  logic             curHasReq;

  assign anyValid  = |reqValid;
  assign curHasReq = reqValid[curQ];
  assign expired   = (timeoutCfg != '0) && (dwellCnt >= timeoutCfg);
  assign dwellNext = (dwellCnt == TMR_MAX) ? dwellCnt : dwellCnt + 1'b1;

  // round-robin scan starting after the current queue; smallest offset wins
  always_comb begin
    candQ = curQ;
    for (int k = NUM_Q; k >= 1; k--) begin
      int s;
      s = int'(curQ) + k;
      if (s >= NUM_Q) s = s - NUM_Q;
      if (reqValid[s]) candQ = QW'(s);
    end
  end

  always_comb begin
    strobe.showReload  = (state == SCH_RELOAD);
    strobe.showReq     = (state == SCH_DRAIN) && curHasReq && !expired;
    strobe.commitModel = (state == SCH_RELOAD) && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SCH_IDLE;
      curQ     <= QW'(NUM_Q - 1);
      dwellCnt <= '0;
    end else begin
      case (state)
        SCH_IDLE: begin
          if (anyValid) begin
            curQ     <= candQ;
            dwellCnt <= '0;
            state    <= candMatch ? SCH_DRAIN : SCH_RELOAD;
          end
        end
        SCH_RELOAD: begin
          dwellCnt <= dwellNext;
          if (outReady) state <= SCH_DRAIN;
        end
        SCH_DRAIN: begin
          dwellCnt <= dwellNext;
          if (!curHasReq || expired) state <= SCH_IDLE;
        end
        default: state <= SCH_IDLE;
      endcase
    end
  end

  // R4: an empty selected queue ends the visit; nothing is shown in the following cycle
  assert_leave_on_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SCH_DRAIN && !curHasReq) |=> (!strobe.showReq && !strobe.showReload));

  // R8: once the dwell window is exhausted, the next cycle issues no request
  assert_dwell_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SCH_DRAIN && timeoutCfg != '0 && dwellCnt >= timeoutCfg) |=> !strobe.showReq);

endmodule

// File: rtl/qs_datapath.sv
module qs_datapath
  import qs_pkg::*;
#(
  parameter int NUM_Q   = 4,
  parameter int DATA_W  = 16,
  parameter int MODEL_W = 4,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_Q*DATA_W-1:0]  reqData,
  input  logic [NUM_Q*MODEL_W-1:0] queueModel,
  input  logic                     outReady,
  input  logic [QW-1:0]            curQ,
  input  logic [QW-1:0]            candQ,
  input  schedStrobe_t             strobe,
  output logic                     candMatch,
  output logic [NUM_Q-1:0]         reqReady,
  output logic                     outValid,
  output logic                     outIsReload,
  output logic [MODEL_W-1:0]       outModel,
  output logic [DATA_W-1:0]        outData
);

  logic [DATA_W-1:0]  dataArr  [NUM_Q];
  logic [MODEL_W-1:0] modelArr [NUM_Q];
  logic [MODEL_W-1:0] loadedModel;
  logic               loadedValid;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_slice
    assign dataArr[q]  = reqData[q*DATA_W +: DATA_W];
    assign modelArr[q] = queueModel[q*MODEL_W +: MODEL_W];
    assign reqReady[q] = strobe.showReq && outReady && (curQ == QW'(q));
  end

  assign candMatch   = loadedValid && (modelArr[candQ] == loadedModel);
  assign outValid    = strobe.showReload || strobe.showReq;
  assign outIsReload = strobe.showReload;
  assign outModel    = modelArr[curQ];
  assign outData     = strobe.showReq ? dataArr[curQ] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loadedModel <= '0;
      loadedValid <= 1'b0;
    end else if (strobe.commitModel) begin
      loadedModel <= modelArr[curQ];
      loadedValid <= 1'b1;
    end
  end

  // R5: a request only leaves under the model already loaded downstream
  assert_req_under_loaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outIsReload) |-> (loadedValid && outModel == loadedModel));

  // R6: a reload is never emitted for the model that is already loaded
  assert_reload_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outIsReload) |-> !(loadedValid && outModel == loadedModel));

  // R7: a stalled reload stays on the output unchanged
  assert_reload_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outIsReload && !outReady) |=> (outValid && outIsReload && $stable(outModel)));

  // R2: at most one queue is granted per cycle
  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqReady));

  // R2: a grant only accompanies an accepted request transfer
  assert_grant_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|reqReady) |-> (outValid && outReady && !outIsReload));

endmodule

// File: rtl/model_queue_sched.sv
module model_queue_sched
  import qs_pkg::*;
#(
  parameter int NUM_Q   = 4,
  parameter int DATA_W  = 16,
  parameter int MODEL_W = 4,
  parameter int TMR_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_Q-1:0]         reqValid,
  output logic [NUM_Q-1:0]         reqReady,
  input  logic [NUM_Q*DATA_W-1:0]  reqData,
  input  logic [NUM_Q*MODEL_W-1:0] queueModel,
  input  logic [TMR_W-1:0]         timeoutCfg,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     outIsReload,
  output logic [MODEL_W-1:0]       outModel,
  output logic [DATA_W-1:0]        outData
);

  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic [QW-1:0] curQ;
  logic [QW-1:0] candQ;
  logic          candMatch;
  schedStrobe_t  strobe;

  qs_ctrl #(
    .NUM_Q (NUM_Q),
    .TMR_W (TMR_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .timeoutCfg (timeoutCfg),
    .outReady   (outReady),
    .candMatch  (candMatch),
    .curQ       (curQ),
    .candQ      (candQ),
    .strobe     (strobe)
  );

  qs_datapath #(
    .NUM_Q   (NUM_Q),
    .DATA_W  (DATA_W),
    .MODEL_W (MODEL_W)
  ) i_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqData     (reqData),
    .queueModel  (queueModel),
    .outReady    (outReady),
    .curQ        (curQ),
    .candQ       (candQ),
    .strobe      (strobe),
    .candMatch   (candMatch),
    .reqReady    (reqReady),
    .outValid    (outValid),
    .outIsReload (outIsReload),
    .outModel    (outModel),
    .outData     (outData)
  );

endmodule

// File: tb/test_model_queue_sched.sv
module test_model_queue_sched;

  localparam int NQ = 4;
  localparam int DW = 16;
  localparam int MW = 4;
  localparam int TW = 8;
  localparam int LOGN = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic             rst_n;
  logic [NQ-1:0]    reqValid;
  logic [NQ-1:0]    reqReady;
  logic [NQ*DW-1:0] reqData;
  logic [NQ*MW-1:0] queueModel;
  logic [TW-1:0]    timeoutCfg;
  logic             outValid;
  logic             outReady;
  logic             outIsReload;
  logic [MW-1:0]    outModel;
  logic [DW-1:0]    outData;

  model_queue_sched #(.NUM_Q(NQ), .DATA_W(DW), .MODEL_W(MW), .TMR_W(TW)) i_model_queue_sched (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady), .reqData(reqData),
    .queueModel(queueModel), .timeoutCfg(timeoutCfg), .outValid(outValid), .outReady(outReady),
    .outIsReload(outIsReload), .outModel(outModel), .outData(outData)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit bpMode  = 1'b0;

  int pend   [NQ];
  int served [NQ];

  // queue q presents payload {q, sequence number}
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      reqValid[q]         = (pend[q] > 0);
      reqData[q*DW +: DW] = {4'(q), 12'(served[q])};
    end
  end

  always @(posedge clk) begin
    for (int q = 0; q < NQ; q++)
      if (reqReady[q] && reqValid[q]) begin
        pend[q]   <= pend[q] - 1;
        served[q] <= served[q] + 1;
      end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // log of accepted output transfers
  logic          logRel   [LOGN];
  logic [MW-1:0] logModel [LOGN];
  logic [DW-1:0] logData  [LOGN];
  int  logN = 0;
  bit  stallPrev = 1'b0;
  logic [MW-1:0] stallModel = '0;

  always @(negedge clk) begin
    cyc++;
    outReady = bpMode ? ((cyc % 3) != 1) : 1'b1;
    #0;
    if (rst_n) begin
      // R7: a reload stalled last cycle must still be shown, unchanged, with no grant
      if (stallPrev)
        chk(outValid && outIsReload && outModel == stallModel && reqReady == '0,
            "R7", "stalled reload held", int'(outModel), int'(stallModel));
      // R2: a grant comes only with an accepted request
      if (reqReady != '0)
        chk($onehot(reqReady) && outValid && outReady && !outIsReload,
            "R2", "grant with transfer", int'(reqReady), 1);
      stallPrev  = outValid && outIsReload && !outReady;
      stallModel = outModel;
      if (outValid && outReady && logN < LOGN) begin
        logRel[logN]   = outIsReload;
        logModel[logN] = outModel;
        logData[logN]  = outData;
        logN++;
      end
    end
  end

  // reference state carried across cases
  int refCur = NQ - 1;
  bit refValid = 1'b0;  // R1: nothing loaded after reset
  int refModel = 0;

  task automatic runCase(input int m[NQ], input int c[NQ], input int t, input bit bp);
    bit eRel [LOGN];
    int eModel [LOGN];
    int eData [LOGN];
    int eN = 0;
    int rem [NQ];
    int seq [NQ];
    int expRel = 0, gotRel = 0, nonEmpty = 0;
    string reqTag;
    for (int q = 0; q < NQ; q++) begin
      rem[q] = c[q]; seq[q] = 0;
      if (c[q] > 0) nonEmpty++;
    end
    // transaction-level expectation
    while ((rem[0] + rem[1] + rem[2] + rem[3]) > 0) begin
      int p = refCur;
      bit rel;
      int lim;
      for (int k = NQ; k >= 1; k--) begin
        int s = (refCur + k) % NQ;
        if (rem[s] > 0) p = s;
      end
      refCur = p;
      rel = !refValid || (m[p] != refModel);
      if (rel) begin
        eRel[eN] = 1'b1; eModel[eN] = m[p]; eData[eN] = 0; eN++;
        refValid = 1'b1; refModel = m[p]; expRel++;
      end
      lim = (t == 0) ? 1000 : (rel ? t - 1 : t);
      while (lim > 0 && rem[p] > 0) begin
        eRel[eN] = 1'b0; eModel[eN] = m[p]; eData[eN] = p * 4096 + seq[p]; eN++;
        seq[p]++; rem[p]--; lim--;
      end
    end

    @(negedge clk);
    bpMode = bp;
    logN = 0;
    stallPrev = 1'b0;
    timeoutCfg = TW'(t);
    for (int q = 0; q < NQ; q++) begin
      queueModel[q*MW +: MW] = MW'(m[q]);
      served[q] = 0;
      pend[q]   = c[q];
    end
    for (int w = 0; w < 600; w++) begin
      @(negedge clk);
      if ((pend[0] + pend[1] + pend[2] + pend[3]) == 0 && logN >= eN) break;
    end
    bpMode = 1'b0;
    // R10: all queues empty -> nothing offered, nothing granted
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      chk(!outValid && reqReady == '0, "R10", "idle when empty", int'(outValid), 0);
    end

    // R4: total transfer count and rotation order
    chk(logN == eN, "R4", "transfer count", logN, eN);
    reqTag = (t != 0) ? "R8" : "R3";
    for (int i = 0; i < eN && i < logN; i++) begin
      if (logRel[i]) gotRel++;
      if (eRel[i]) begin
        // R5: reload command with new model and zero payload
        chk(logRel[i] && int'(logModel[i]) == eModel[i] && logData[i] == '0,
            "R5", "reload item", int'(logModel[i]) + (logRel[i] ? 0 : 100), eModel[i]);
      end else begin
        // R2/R3/R8: request payload and model in expected order
        chk(!logRel[i] && int'(logData[i]) == eData[i] && int'(logModel[i]) == eModel[i],
            reqTag, "request item", int'(logData[i]), eData[i]);
      end
    end
    // R6 (shared models) and R9 (single queue under timeout): reload count
    chk(gotRel == expRel, (t != 0 && nonEmpty == 1) ? "R9" : "R6", "reload count", gotRel, expRel);
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      nFail++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int mp [3][NQ];
    int tv [3];
    mp[0] = '{1, 2, 3, 4};
    mp[1] = '{5, 5, 6, 6};
    mp[2] = '{7, 7, 7, 7};
    tv = '{0, 2, 4};
    rst_n = 1'b0;
    timeoutCfg = '0;
    queueModel = '0;
    for (int q = 0; q < NQ; q++) begin pend[q] = 0; served[q] = 0; end
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(!outValid && reqReady == '0, "R1", "reset outputs", int'(outValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!outValid && reqReady == '0, "R1", "idle after reset", int'(reqReady), 0);

    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int code = 0; code < 81; code++) begin
          int c [NQ];
          c[0] = code % 3; c[1] = (code / 3) % 3; c[2] = (code / 9) % 3; c[3] = (code / 27) % 3;
          runCase(mp[a], c, tv[b], 1'b0);
        end
    // backpressure pass, no dwell limit (R7)
    for (int a = 0; a < 3; a++)
      for (int code = 0; code < 81; code++) begin
        int c [NQ];
        c[0] = code % 3; c[1] = (code / 3) % 3; c[2] = (code / 9) % 3; c[3] = (code / 27) % 3;
        runCase(mp[a], c, 0, 1'b1);
      end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule